// File: doc/BRIEF.md
# Edge-Cleared Watchdog Timer

This block watches a single activity line from software or a peer block and reports when that line stops changing. Each rising or falling transition on the line restarts an internal cycle counter. If the line holds one level long enough for the counter to reach the timeout, the active-low watchdog output drops. It stays low until the next transition clears the counter.

The block also takes two signals from the neighbouring reset generator: a supply-good flag and a reset-active flag. Either one holds the counter at zero. While the supply is bad, the watchdog output is also forced low. When the supply recovers, the output rises in the same cycle, with no hold-off. An optional one-cycle timeout pulse marks the moment the output falls because of inactivity.

The activity line is asynchronous. It passes through a parameterised synchronizer, and transitions are found by comparing each synchronized sample with the previous one.

Top module: `edge_watchdog`

## Requirements
- R1: While `rst_n` is low and after its release, the counter is zero and `timeout_pulse` is 0. With `supply_good` high, `wd_out_n` is 1.
- R2: `wd_in` passes through `SYNC_STAGES` flops, and a change on it is detected one cycle later. A change first sampled at clock edge k clears the counter at edge k+`SYNC_STAGES`. If no further clear occurs, `wd_out_n` falls at edge k+`SYNC_STAGES`+`TIMEOUT`.
- R3: A detected rising transition of `wd_in` clears the counter.
- R4: A detected falling transition of `wd_in` clears the counter.
- R5: Toggling `wd_in` on every clock cycle keeps `wd_out_n` high indefinitely.
- R6: The counter saturates at `TIMEOUT` and never wraps. After a timeout, `wd_out_n` stays low until a transition clears the counter. It returns high at the clock edge that applies that clear.
- R7: While `gen_reset` (active high) is 1, the counter is held at zero, so `wd_out_n` stays high when the supply is good.
- R8: While `supply_good` is 0, `wd_out_n` is 0 in the same cycle, regardless of `wd_in` activity, and the counter is held at zero.
- R9: In the cycle `supply_good` returns to 1, `wd_out_n` is 1 at once.
- R10: When `PULSE_EN` is 1, `timeout_pulse` is high for exactly one cycle. That cycle is the one in which the counter reaches `TIMEOUT`, and the pulse occurs at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| wd_in | input | 1 | Asynchronous activity line; each transition restarts the timer |
| gen_reset | input | 1 | Reset-active flag from the reset generator (active high) |
| supply_good | input | 1 | Supply above threshold (active high) |
| wd_out_n | output | 1 | Watchdog output, low on timeout or bad supply |
| timeout_pulse | output | 1 | One-cycle strobe when the timeout is reached |

## Verification
The hardest state to reach is a saturated counter that stays low across a long idle period and then releases on exactly the right edge. Reaching it needs silence on `wd_in`, `gen_reset` and `supply_good` for more than `TIMEOUT` cycles. Uniform random toggling almost never produces that. The random stimulus therefore draws gap lengths on both sides of the timeout, with some longer than it. Directed cases also hold the line well past saturation, then measure the exact fall cycle and the recovery cycle. A supply drop that lands during a saturated period is aimed at separately, to show the output releases at once when the supply returns.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef struct packed {
    logic kick;
    logic gen_rst;
    logic low_supply;
  } wdt_clear_t;

  function automatic logic clear_any(input wdt_clear_t c);
    return c.kick | c.gen_rst | c.low_supply;
  endfunction

endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];

  initial begin
    stages_min_chk: assert (STAGES >= 2);
  end
endmodule

// File: rtl/wdt_edge.sv
module wdt_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic kick
);
  logic prev_q;
  logic prev_d;

  always_comb prev_d = level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign kick = level ^ prev_q;
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int TIMEOUT = 40,
  localparam int CW = $clog2(TIMEOUT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  output logic [CW-1:0] count,
  output logic          expired,
  output logic          reach
);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clear | (cnt_q != LIMIT);
    if (clear) cnt_d = '0;
    else       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count   = cnt_q;
  assign expired = (cnt_q == LIMIT);
  assign reach   = !clear && (cnt_q == LIMIT - 1'b1);

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);
  // R6
  saturate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !clear) |=> expired);
  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !expired) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/edge_watchdog.sv
module edge_watchdog #(
  parameter int TIMEOUT     = 40,
  parameter int SYNC_STAGES = 2,
  parameter bit PULSE_EN    = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wd_in,
  input  logic gen_reset,
  input  logic supply_good,
  output logic wd_out_n,
  output logic timeout_pulse
);
  import wdt_pkg::*;
  localparam int CW = $clog2(TIMEOUT + 1);

  logic          wd_sync;
  logic          kick;
  logic          clear;
  logic          expired;
  logic          reach;
  logic [CW-1:0] count;
  wdt_clear_t    clr_src;

  wdt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(wd_in), .q(wd_sync)
  );

  wdt_edge u_edge (
    .clk(clk), .rst_n(rst_n), .level(wd_sync), .kick(kick)
  );

  always_comb begin
    clr_src.kick       = kick;
    clr_src.gen_rst    = gen_reset;
    clr_src.low_supply = !supply_good;
    clear              = clear_any(clr_src);
  end

  wdt_counter #(.TIMEOUT(TIMEOUT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .count(count), .expired(expired), .reach(reach)
  );

  assign wd_out_n = supply_good & ~expired;

  generate
    if (PULSE_EN) begin : g_pulse
      logic pulse_q, pulse_d;
      always_comb pulse_d = reach;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= pulse_d;
      end
      assign timeout_pulse = pulse_q;
    end else begin : g_no_pulse
      assign timeout_pulse = 1'b0;
    end
  endgenerate

  // R9
  supply_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(supply_good) |-> wd_out_n);
  // R8
  supply_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_good |=> (count == '0));
  // R3
  kick_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (count == '0));
  // R10
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |=> !timeout_pulse);
  // R10
  pulse_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |-> !wd_out_n);
  // R7
  genrst_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_reset && supply_good) |=> (wd_out_n || !supply_good));
endmodule

// File: tb/edge_watchdog_test.sv
module edge_watchdog_test;
  localparam int T = 40;
  localparam int S = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic wd_in, gen_reset, supply_good;
  logic wd_out_n, timeout_pulse;

  int tests = 0;
  int fails = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  edge_watchdog #(.TIMEOUT(T), .SYNC_STAGES(S), .PULSE_EN(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .wd_in(wd_in), .gen_reset(gen_reset),
    .supply_good(supply_good), .wd_out_n(wd_out_n), .timeout_pulse(timeout_pulse)
  );

  // Requirement-level reference: input delay line, idle counter, pulse.
  logic [S:0] pipe_m;
  int         cnt_m;
  logic       pulse_m;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_m  <= '0;
      cnt_m   <= 0;
      pulse_m <= 1'b0;
    end else begin
      logic clr;
      clr = (pipe_m[S-1] != pipe_m[S]) || gen_reset || !supply_good;
      cnt_m   <= clr ? 0 : ((cnt_m == T) ? T : cnt_m + 1);
      pulse_m <= !clr && (cnt_m == T - 1);
      pipe_m  <= {pipe_m[S-1:0], wd_in};
    end
  end

  function automatic logic exp_out(input logic sup, input int c);
    return sup && (c != T);
  endfunction

  task automatic check(input string req, input logic act, input logic exp, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    check(cur_req, wd_out_n, exp_out(supply_good, cnt_m), "wd_out_n");
    check(cur_req, timeout_pulse, pulse_m, "timeout_pulse");
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int lat;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; wd_in = 1'b0; gen_reset = 1'b0; supply_good = 1'b1;
    #35;
    // R1 reset state
    check("R1", wd_out_n, 1'b1, "wd_out_n in reset");
    check("R1", timeout_pulse, 1'b0, "pulse in reset");
    @(negedge clk); rst_n = 1'b1;
    cur_req = "R1"; ticks(3);

    // R2 exact latency from a held change
    cur_req = "R2";
    wd_in = 1'b1; ticks(4);
    wd_in = 1'b0;
    lat = 0;
    for (int i = 0; i < T + 10; i++) begin
      tick(); lat++;
      if (!wd_out_n) break;
    end
    check("R2", (lat == S + T + 1), 1'b1, "fall latency matches");

    // R6 saturation: stays low well past timeout, then releases on clear edge
    cur_req = "R6"; ticks(3 * T);
    check("R6", wd_out_n, 1'b0, "held low while saturated");
    wd_in = 1'b1; ticks(S);
    check("R6", wd_out_n, 1'b0, "still low before detection");
    tick();
    check("R6", wd_out_n, 1'b1, "released by clear edge");

    // R3 rising and R4 falling kicks just before timeout
    cur_req = "R4"; wd_in = 1'b0; ticks(T - 3);
    cur_req = "R3"; wd_in = 1'b1; ticks(T - 3);
    check("R3", wd_out_n, 1'b1, "rising kick avoided timeout");
    cur_req = "R4"; wd_in = 1'b0; ticks(T - 3);
    check("R4", wd_out_n, 1'b1, "falling kick avoided timeout");

    // R5 toggle every cycle
    cur_req = "R5";
    for (int i = 0; i < 4 * T; i++) begin wd_in = ~wd_in; tick(); end
    check("R5", wd_out_n, 1'b1, "toggling keeps output high");

    // R7 generator reset holds counter clear
    cur_req = "R7"; gen_reset = 1'b1; ticks(3 * T);
    check("R7", wd_out_n, 1'b1, "held clear under gen_reset");
    gen_reset = 1'b0;

    // R8 / R9 supply drop during a saturated period
    cur_req = "R6"; ticks(T + 5);
    check("R6", wd_out_n, 1'b0, "timed out before supply drop");
    cur_req = "R8"; supply_good = 1'b0;
    #1; check("R8", wd_out_n, 1'b0, "forced low same cycle");
    for (int i = 0; i < 10; i++) begin wd_in = ~wd_in; tick(); end
    cur_req = "R9"; @(negedge clk); supply_good = 1'b1;
    #1; check("R9", wd_out_n, 1'b1, "released at once");
    ticks(2);

    // R10 pulse counted over one timeout
    cur_req = "R10";
    wd_in = ~wd_in; ticks(S + 1);
    lat = 0;
    for (int i = 0; i < T + 5; i++) begin tick(); if (timeout_pulse) lat++; end
    check("R10", (lat == 1), 1'b1, "exactly one pulse");

    // Random mix around the timeout
    for (int n = 0; n < 600; n++) begin
      int r, gap;
      r = $urandom_range(0, 99);
      if (r < 8) begin
        cur_req = "R8"; supply_good = 1'b0; ticks($urandom_range(1, 8));
        cur_req = "R9"; supply_good = 1'b1; tick();
      end else if (r < 14) begin
        cur_req = "R7"; gen_reset = 1'b1; ticks($urandom_range(1, 8));
        gen_reset = 1'b0; tick();
      end else begin
        gap = $urandom_range(1, T + 15);
        cur_req = (gap > T) ? "R10" : (wd_in ? "R4" : "R3");
        wd_in = ~wd_in;
        ticks(gap);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule